// File: doc/BRIEF.md
# Signed Halfword Divide Unit

This block is the multi-cycle divider of a processor execute stage. It divides a 32-bit signed dividend by a signed 16-bit divisor, taken as the sign-extended low halfword of a 32-bit source operand, and returns a 32-bit quotient and a 32-bit remainder. It also returns write enables for the quotient and remainder destination registers and an updated set of condition flags (overflow, sign, zero, carry, saturation).

The issuing stage pulses `start` with the operands, the two destination register indices and the current flag values. The unit works on magnitudes with a restoring shift-subtract loop of one step per clock, fixes the signs at the end and pulses `done` for one cycle. During that cycle the results, destination indices, write enables and flags are valid. A zero divisor and the most-negative-by-minus-one case are recognised when the operation is accepted, and finish after a single cycle.

Top module: `hdiv_unit`

## Requirements
- R1: Only `divisorOp[15:0]` is used, as a signed 16-bit value. Bits [31:16] have no effect, so 0x0000FFFA divides as -6 and 0xFFFF0000 divides as zero.
- R2: The quotient truncates toward zero and the remainder has the sign of the dividend. For example, 45 / -6 gives -7 rem 3, -45 / 6 gives -7 rem -3, and -45 / -6 gives 7 rem -3.
- R3: On a completion with a nonzero divisor, `signOut` equals quotient bit 31 and `zeroOut` is 1 exactly when the quotient is zero. The remainder does not affect either flag, so 16 / 45 gives zeroOut=1 with remainder 16.
- R4: A division with a nonzero divisor, other than the overflow case, clears `ovOut`. On that completion `quoWe`/`remWe` pulse together with `done`, addressed by `quoIdxOut`/`remIdxOut`, and the write enables are 0 in every other cycle.
- R5: When `divisorOp[15:0]` is zero, `ovOut` is 1 and both write enables stay 0. `signOut`, `zeroOut`, `carryOut` and `satOut` equal the values given at start, and `quotient`/`remainder` keep their previous values.
- R6: A dividend of 0x80000000 with a divisor of -1 gives quotient 0x80000000 and remainder 0, with ovOut=1, signOut=1 and zeroOut=0. Both results are written.
- R7: A zero dividend with a nonzero divisor completes normally, with quotient 0, remainder 0, zeroOut=1 and ovOut=0.
- R8: When `quoIdx` equals `remIdx`, only the remainder is written: quoWe=0 and remWe=1.
- R9: `carryOut` and `satOut` equal the `carryIn` and `satIn` values captured at start, in every case.
- R10: `done` rises 33 clock edges after the edge that accepts `start` for an ordinary division. It rises 1 edge after that edge for the zero-divisor and overflow cases.
- R11: `done` is a single-cycle pulse, given exactly once per accepted start.
- R12: A `start` while `busy` is 1 is ignored. The result, index and flag outputs change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division (accepted when not busy) |
| dividend | input | 32 | Signed dividend |
| divisorOp | input | 32 | Source operand; low halfword is the signed divisor |
| quoIdx | input | 5 | Quotient destination register index |
| remIdx | input | 5 | Remainder destination register index |
| ovIn | input | 1 | Incoming overflow flag |
| signIn | input | 1 | Incoming sign flag |
| zeroIn | input | 1 | Incoming zero flag |
| carryIn | input | 1 | Incoming carry flag |
| satIn | input | 1 | Incoming saturation flag |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Signed quotient |
| remainder | output | 32 | Signed remainder |
| quoWe | output | 1 | Quotient register write enable |
| remWe | output | 1 | Remainder register write enable |
| quoIdxOut | output | 5 | Quotient destination index of the completed operation |
| remIdxOut | output | 5 | Remainder destination index of the completed operation |
| ovOut | output | 1 | Updated overflow flag |
| signOut | output | 1 | Updated sign flag |
| zeroOut | output | 1 | Updated zero flag |
| carryOut | output | 1 | Carry flag (pass-through) |
| satOut | output | 1 | Saturation flag (pass-through) |

## Verification
The hardest case to reach is a second `start` that arrives mid-loop. If the unit wrongly accepts it, the running magnitude registers are reloaded, or a second `done` appears, and neither shows unless the first result is watched closely. The stimulus issues one division, pulses `start` with different operands five cycles later, and then checks three things: the first operation's quotient, remainder and indices come out; the outputs stay frozen until then; and no further completion follows. The zero-divisor cases use a nonzero upper halfword and all incoming flags set, so that any flag the unit wrongly recomputes is visible.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture operands, indices and flags
    logic step;    // one restoring shift-subtract iteration
    logic commit;  // publish results and flags
  } hdivStrobes_t;

endpackage

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl
  import hdiv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         special,
  output hdivStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

  state_t          state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes        = '0;
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_RUN);
    strobes.commit = (state == ST_FIN);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = special ? ST_FIN : ST_RUN;
      ST_RUN:  if (stepCnt == LAST_STEP) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.commit;
      if (strobes.load)      stepCnt <= '0;
      else if (strobes.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/hdiv_datapath.sv
module hdiv_datapath
  import hdiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdivStrobes_t      strobes,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisorOp,
  input  logic [IDX_W-1:0]  quoIdx,
  input  logic [IDX_W-1:0]  remIdx,
  input  logic              ovIn,
  input  logic              signIn,
  input  logic              zeroIn,
  input  logic              carryIn,
  input  logic              satIn,
  output logic              special,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              quoWe,
  output logic              remWe,
  output logic [IDX_W-1:0]  quoIdxOut,
  output logic [IDX_W-1:0]  remIdxOut,
  output logic              ovOut,
  output logic              signOut,
  output logic              zeroOut,
  output logic              carryOut,
  output logic              satOut
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // Operand decode (combinational, from the ports)
  logic [DATA_W-1:0] divisorExt;
  logic              inDivZero;
  logic              inOverflow;
  logic              unusedHiBits;

  assign divisorExt   = {{(DATA_W-DIV_W){divisorOp[DIV_W-1]}}, divisorOp[DIV_W-1:0]};
  assign unusedHiBits = ^divisorOp[DATA_W-1:DIV_W];
  assign inDivZero    = (divisorOp[DIV_W-1:0] == '0);
  assign inOverflow   = (dividend == MOST_NEG) && (divisorOp[DIV_W-1:0] == '1);
  assign special      = inDivZero || inOverflow;

  // Working state
  logic [DATA_W-1:0] remAcc;
  logic [DATA_W-1:0] quoSh;
  logic [DATA_W-1:0] dvsMag;
  logic              negQuo, negRem;
  logic              caseDivZero, caseOverflow;
  logic [IDX_W-1:0]  quoIdxR, remIdxR;
  logic              ovR, signR, zeroR, carryR, satR;

  // One restoring iteration
  logic [DATA_W:0]   trial;
  logic [DATA_W-1:0] shifted;
  logic              fits;

  assign trial   = {remAcc, quoSh[DATA_W-1]} - {1'b0, dvsMag};
  assign shifted = {remAcc[DATA_W-2:0], quoSh[DATA_W-1]};
  assign fits    = !trial[DATA_W];

  // Sign correction
  logic [DATA_W-1:0] quoSigned, remSigned;
  logic [DATA_W-1:0] quoFinal, remFinal;
  logic              collide;

  assign quoSigned = negQuo ? (~quoSh + 1'b1) : quoSh;
  assign remSigned = negRem ? (~remAcc + 1'b1) : remAcc;
  assign quoFinal  = caseOverflow ? MOST_NEG : quoSigned;
  assign remFinal  = caseOverflow ? '0 : remSigned;
  assign collide   = (quoIdxR == remIdxR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remAcc       <= '0;
      quoSh        <= '0;
      dvsMag       <= '0;
      negQuo       <= 1'b0;
      negRem       <= 1'b0;
      caseDivZero  <= 1'b0;
      caseOverflow <= 1'b0;
      quoIdxR      <= '0;
      remIdxR      <= '0;
      {ovR, signR, zeroR, carryR, satR} <= '0;
    end else if (strobes.load) begin
      remAcc       <= '0;
      quoSh        <= dividend[DATA_W-1] ? (~dividend + 1'b1) : dividend;
      dvsMag       <= divisorExt[DATA_W-1] ? (~divisorExt + 1'b1) : divisorExt;
      negQuo       <= dividend[DATA_W-1] ^ divisorExt[DATA_W-1];
      negRem       <= dividend[DATA_W-1];
      caseDivZero  <= inDivZero;
      caseOverflow <= inOverflow;
      quoIdxR      <= quoIdx;
      remIdxR      <= remIdx;
      {ovR, signR, zeroR, carryR, satR} <= {ovIn, signIn, zeroIn, carryIn, satIn};
    end else if (strobes.step) begin
      remAcc <= fits ? trial[DATA_W-1:0] : shifted;
      quoSh  <= {quoSh[DATA_W-2:0], fits};
    end
  end

  // Published outputs: change only on commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      quoWe     <= 1'b0;
      remWe     <= 1'b0;
      quoIdxOut <= '0;
      remIdxOut <= '0;
      ovOut     <= 1'b0;
      signOut   <= 1'b0;
      zeroOut   <= 1'b0;
      carryOut  <= 1'b0;
      satOut    <= 1'b0;
    end else if (strobes.commit) begin
      quoIdxOut <= quoIdxR;
      remIdxOut <= remIdxR;
      carryOut  <= carryR;
      satOut    <= satR;
      if (caseDivZero) begin
        quoWe   <= 1'b0;
        remWe   <= 1'b0;
        ovOut   <= 1'b1;
        signOut <= signR;
        zeroOut <= zeroR;
      end else begin
        quotient  <= quoFinal;
        remainder <= remFinal;
        quoWe     <= !collide;
        remWe     <= 1'b1;
        ovOut     <= caseOverflow;
        signOut   <= quoFinal[DATA_W-1];
        zeroOut   <= (quoFinal == '0);
      end
    end else begin
      quoWe <= 1'b0;
      remWe <= 1'b0;
    end
  end

  // ovR is captured for completeness of the flag bundle but never republished
  logic unusedOvIn;
  assign unusedOvIn = ovR;

endmodule

// File: rtl/hdiv_unit.sv
module hdiv_unit
  import hdiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisorOp,
  input  logic [IDX_W-1:0]  quoIdx,
  input  logic [IDX_W-1:0]  remIdx,
  input  logic              ovIn,
  input  logic              signIn,
  input  logic              zeroIn,
  input  logic              carryIn,
  input  logic              satIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              quoWe,
  output logic              remWe,
  output logic [IDX_W-1:0]  quoIdxOut,
  output logic [IDX_W-1:0]  remIdxOut,
  output logic              ovOut,
  output logic              signOut,
  output logic              zeroOut,
  output logic              carryOut,
  output logic              satOut
);

  hdivStrobes_t strobes;
  logic         special;

  hdiv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .special (special),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  hdiv_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dividend  (dividend),
    .divisorOp (divisorOp),
    .quoIdx    (quoIdx),
    .remIdx    (remIdx),
    .ovIn      (ovIn),
    .signIn    (signIn),
    .zeroIn    (zeroIn),
    .carryIn   (carryIn),
    .satIn     (satIn),
    .special   (special),
    .quotient  (quotient),
    .remainder (remainder),
    .quoWe     (quoWe),
    .remWe     (remWe),
    .quoIdxOut (quoIdxOut),
    .remIdxOut (remIdxOut),
    .ovOut     (ovOut),
    .signOut   (signOut),
    .zeroOut   (zeroOut),
    .carryOut  (carryOut),
    .satOut    (satOut)
  );

endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] dividend,
  input logic [DATA_W-1:0] divisorOp,
  input logic              carryIn,
  input logic              satIn,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] quotient,
  input logic [DATA_W-1:0] remainder,
  input logic              quoWe,
  input logic              remWe,
  input logic [IDX_W-1:0]  quoIdxOut,
  input logic [IDX_W-1:0]  remIdxOut,
  input logic              ovOut,
  input logic              signOut,
  input logic              zeroOut,
  input logic              carryOut,
  input logic              satOut
);

  localparam int LAT_W = $clog2(DATA_W + 2) + 1;
  localparam logic [LAT_W-1:0] LAT_NORMAL = LAT_W'(DATA_W + 1);
  localparam logic [LAT_W-1:0] LAT_SHORT  = LAT_W'(1);
  localparam logic [DATA_W-1:0] MOST_NEG  = {1'b1, {(DATA_W-1){1'b0}}};

  logic             accepted;
  logic             pendDz, pendShort, pendCarry, pendSat;
  logic [LAT_W-1:0] latCnt;

  assign accepted = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendDz    <= 1'b0;
      pendShort <= 1'b0;
      pendCarry <= 1'b0;
      pendSat   <= 1'b0;
      latCnt    <= '0;
    end else if (accepted) begin
      pendDz    <= (divisorOp[DIV_W-1:0] == '0);
      pendShort <= (divisorOp[DIV_W-1:0] == '0) ||
                   ((dividend == MOST_NEG) && (divisorOp[DIV_W-1:0] == '1));
      pendCarry <= carryIn;
      pendSat   <= satIn;
      latCnt    <= '0;
    end else if (latCnt != '1) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  // R11: one-cycle completion pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: write enables only accompany done
  a_r4_we_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (quoWe || remWe) |-> done);

  // R5: zero divisor writes nothing and raises overflow
  a_r5_divzero_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    (done && pendDz) |-> (!quoWe && !remWe && ovOut));

  // R8: colliding destinations write only the remainder
  a_r8_collision: assert property (@(posedge clk) disable iff (!rstN)
    (done && (quoIdxOut == remIdxOut)) |-> !quoWe);

  // R3: sign and zero follow the quotient
  a_r3_flags_from_quotient: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pendDz) |-> ((signOut == quotient[DATA_W-1]) && (zeroOut == (quotient == '0))));

  // R9: carry and saturation pass through
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((carryOut == pendCarry) && (satOut == pendSat)));

  // R10: completion latency
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == (pendShort ? LAT_SHORT : LAT_NORMAL)));

  // R12: outputs hold between completions
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(quoIdxOut) && $stable(ovOut)));

endmodule

bind hdiv_unit hdiv_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .dividend  (dividend),
  .divisorOp (divisorOp),
  .carryIn   (carryIn),
  .satIn     (satIn),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .quoWe     (quoWe),
  .remWe     (remWe),
  .quoIdxOut (quoIdxOut),
  .remIdxOut (remIdxOut),
  .ovOut     (ovOut),
  .signOut   (signOut),
  .zeroOut   (zeroOut),
  .carryOut  (carryOut),
  .satOut    (satOut)
);

// File: tb/sim_hdiv_unit.sv
module sim_hdiv_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] dividend, divisorOp;
  logic [4:0]  quoIdx, remIdx;
  logic        ovIn, signIn, zeroIn, carryIn, satIn;
  logic        busy, done, quoWe, remWe;
  logic [31:0] quotient, remainder;
  logic [4:0]  quoIdxOut, remIdxOut;
  logic        ovOut, signOut, zeroOut, carryOut, satOut;

  always #10 clk = ~clk;  // 50 MHz

  hdiv_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisorOp(divisorOp),
    .quoIdx(quoIdx), .remIdx(remIdx), .ovIn(ovIn), .signIn(signIn), .zeroIn(zeroIn),
    .carryIn(carryIn), .satIn(satIn), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .quoWe(quoWe), .remWe(remWe), .quoIdxOut(quoIdxOut),
    .remIdxOut(remIdxOut), .ovOut(ovOut), .signOut(signOut), .zeroOut(zeroOut),
    .carryOut(carryOut), .satOut(satOut)
  );

  int nChecks = 0;
  int nErrors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags field: {ov, s, z, c, sat}
  typedef struct packed {
    logic [31:0] dvd;
    logic [31:0] dvs;
    logic [4:0]  qi;
    logic [4:0]  ri;
    logic [4:0]  fin;
    logic [31:0] expQ;
    logic [31:0] expR;
    logic        expQWe;
    logic        expRWe;
    logic        expOv;
    logic        expS;
    logic        expZ;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    // R2 basic signs
    '{32'h0000002D, 32'h00000006, 5'd3, 5'd4, 5'b00000, 32'h00000007, 32'h00000003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0000002D, 32'hFFFFFFFA, 5'd3, 5'd4, 5'b10010, 32'hFFFFFFF9, 32'h00000003, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'hFFFFFFD3, 32'h00000006, 5'd5, 5'd6, 5'b00001, 32'hFFFFFFF9, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'hFFFFFFD3, 32'hFFFFFFFA, 5'd7, 5'd8, 5'b01100, 32'h00000007, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R1 upper half ignored
    '{32'hFFFFFFD3, 32'h0000FFFA, 5'd1, 5'd2, 5'b00000, 32'h00000007, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0000002D, 32'h12340006, 5'd1, 5'd2, 5'b00010, 32'h00000007, 32'h00000003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R7 zero dividend
    '{32'h00000000, 32'h0000002D, 5'd9, 5'd10, 5'b10000, 32'h00000000, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    // R3 zero flag from quotient only
    '{32'h00000010, 32'h0000002D, 5'd9, 5'd10, 5'b00000, 32'h00000000, 32'h00000010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    // R6 overflow
    '{32'h80000000, 32'hFFFFFFFF, 5'd11, 5'd12, 5'b00100, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    // R5 zero divisor, flags kept
    '{32'h0000002D, 32'h00000000, 5'd13, 5'd14, 5'b00000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h0000002D, 32'hFFFF0000, 5'd13, 5'd14, 5'b01111, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    // R8 collision
    '{32'h0000002D, 32'h00000006, 5'd2, 5'd2, 5'b00000, 32'h00000007, 32'h00000003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    // R2 wide ranges
    '{32'h7FFFFFFF, 32'h00008000, 5'd15, 5'd16, 5'b00000, 32'hFFFF0001, 32'h00007FFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'h80000000, 32'h00000001, 5'd17, 5'd18, 5'b00000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'h80000000, 32'h00007FFF, 5'd19, 5'd20, 5'b00011, 32'hFFFEFFFE, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  // Issue one operation at a negedge; return negedges until done is seen.
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [4:0] qi,
                       input logic [4:0] ri, input logic [4:0] f, output int cycles);
    dividend = a; divisorOp = b; quoIdx = qi; remIdx = ri;
    {ovIn, signIn, zeroIn, carryIn, satIn} = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] prevQ, prevR;
    int extraDone;
    rstN = 1'b0; start = 1'b0; dividend = '0; divisorOp = '0; quoIdx = '0; remIdx = '0;
    {ovIn, signIn, zeroIn, carryIn, satIn} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R4, R11)
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R4 reset write enables", {30'd0, quoWe, remWe}, 32'd0);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset quotient", quotient, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      prevQ = quotient; prevR = remainder;
      runOp(VECS[i].dvd, VECS[i].dvs, VECS[i].qi, VECS[i].ri, VECS[i].fin, cyc);
      // R10 latency: special cases complete one edge after acceptance
      chk("R10 latency", cyc,
          ((VECS[i].dvs[15:0] == 16'h0) || (VECS[i].dvd == 32'h80000000 && VECS[i].dvs[15:0] == 16'hFFFF)) ? 2 : 34);
      if (VECS[i].expRWe) begin
        if (VECS[i].expQWe) chk("R2 quotient", quotient, VECS[i].expQ);
        chk("R2 remainder", remainder, VECS[i].expR);
      end else begin
        chk("R5 quotient held", quotient, prevQ);
        chk("R5 remainder held", remainder, prevR);
      end
      chk("R8 write enables", {30'd0, quoWe, remWe}, {30'd0, VECS[i].expQWe, VECS[i].expRWe});
      chk("R4 indices", {22'd0, quoIdxOut, remIdxOut}, {22'd0, VECS[i].qi, VECS[i].ri});
      chk("R4 overflow", {31'd0, ovOut}, {31'd0, VECS[i].expOv});
      chk("R3 sign zero", {30'd0, signOut, zeroOut}, {30'd0, VECS[i].expS, VECS[i].expZ});
      chk("R9 carry sat", {30'd0, carryOut, satOut}, {30'd0, VECS[i].fin[1], VECS[i].fin[0]});
      @(negedge clk);
      chk("R11 done single pulse", {31'd0, done}, 32'd0);
      chk("R4 enables cleared", {30'd0, quoWe, remWe}, 32'd0);
    end

    // R12: start while busy is ignored, outputs hold until completion
    prevQ = quotient; prevR = remainder;
    dividend = 32'h0000002D; divisorOp = 32'h00000006; quoIdx = 5'd21; remIdx = 5'd22;
    {ovIn, signIn, zeroIn, carryIn, satIn} = 5'b00000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 busy mid-run", {31'd0, busy}, 32'd1);
    dividend = 32'h00000064; divisorOp = 32'h0000000A; quoIdx = 5'd23; remIdx = 5'd24;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      if (quotient !== prevQ || remainder !== prevR) begin
        chk("R12 outputs held while busy", quotient, prevQ);
        prevQ = quotient;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R12 first result quotient", quotient, 32'h7);
    chk("R12 first result remainder", remainder, 32'h3);
    chk("R12 first result indices", {22'd0, quoIdxOut, remIdxOut}, {22'd0, 5'd21, 5'd22});
    extraDone = 0;
    repeat (45) begin
      @(negedge clk);
      if (done) extraDone++;
    end
    chk("R11 R12 no second completion", extraDone, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule